// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block turns one high-level flash request into the series of command-latch and address-latch bytes that a raw NAND device expects. The supported requests are device reset, identifier read, page read, page program and block erase. Each request comes with a page or block index. The block emits each bus cycle as a tagged byte under a valid/ready handshake, so the pin-level timing engine that follows it stays simple.

Before each operation the block waits on the device ready/busy line. Program and erase end with a status-read command, and the block judges pass or fail from the returned byte. Program hands off to an external data mover for the page payload and resumes when that transfer ends. Configuration inputs choose small pages (512 bytes) or large pages (2048 bytes), 64 or 128 pages per large-page block, and an extra address byte for big devices. They also set the device size in blocks, which is used to reject indices that are out of range.

Top module: `nand_seq`

## Requirements
- R1: While reset is held and just after it is released, busy, done, cyc_valid, xfer_req and stat_req are all 0.
- R2: A request is taken when req_valid is high and busy is low. busy stays high from the next cycle through the done cycle. done is a one-cycle pulse. A request offered while busy is ignored.
- R3: A bus cycle is offered with cyc_valid. cyc_is_addr is 1 for an address byte and 0 for a command byte. Tag and byte hold steady until a cycle with cyc_ready high, and cycles are delivered in order under any pattern of cyc_ready.
- R4: Op code 0 (reset) emits the single command 0xFF without waiting for ready, then completes with pass=1.
- R5: Op code 1 (identifier read) waits for nand_rdy, emits command 0x90 and address 0x00, waits for nand_rdy again and completes with pass=1.
- R6: Op code 2 (page read) waits for nand_rdy and emits command 0x00. It then sends the column bytes: one 0x00 in small-page mode, two 0x00 in large-page mode. Next come index[7:0] and index[15:8], and index[23:16] only when cfg_extra is 1. In large-page mode a command 0x30 follows. The block then waits for nand_rdy and completes with pass=1.
- R7: Op code 3 (page program) waits for nand_rdy and emits command 0x80 with the page address of R6. It then holds xfer_req high until xfer_done, emits command 0x10 and finishes with the status check of R10.
- R8: Op code 4 (block erase) waits for nand_rdy and emits command 0x60. It then sends the row value (index shifted left by S) as bits [7:0] and [15:8], and bits [23:16] only when cfg_extra is 1. Command 0xD0 follows, and the operation finishes with the status check of R10.
- R9: Pages per block is 2^S, where S is 5 when cfg_large=0, 6 when cfg_large=1 and cfg_blk128=0, and 7 when cfg_large=1 and cfg_blk128=1.
- R10: The status check waits for nand_rdy and emits command 0x70. It then holds stat_req high until stat_valid. pass is 1 only when bit 6 (ready) of stat_byte is 1 and bit 0 (error) is 0.
- R11: The following requests are rejected: page ops (codes 2, 3) with index >= cfg_blocks*2^S, erase with index >= cfg_blocks, and op codes 5 to 7. A rejected request emits no bus cycle and completes on the cycle after acceptance with bad_idx=1 and pass=0.
- R12: For op codes 1 to 4, no bus cycle is offered while nand_rdy is low at the start of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_op | input | 3 | Operation code |
| req_index | input | 24 | Page index, or block index for erase |
| cfg_large | input | 1 | 1 selects 2048-byte pages |
| cfg_blk128 | input | 1 | Large pages: 1 selects 128 pages per block, 0 selects 64 |
| cfg_extra | input | 1 | Send the third row address byte |
| cfg_blocks | input | BLK_W | Device size in blocks |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with done |
| bad_idx | output | 1 | Request rejected, valid with done |
| cyc_valid | output | 1 | Bus cycle offered |
| cyc_ready | input | 1 | Bus cycle accepted |
| cyc_is_addr | output | 1 | 1 = address byte, 0 = command byte |
| cyc_byte | output | 8 | Bus cycle value |
| nand_rdy | input | 1 | Device ready/busy line, 1 = ready |
| xfer_req | output | 1 | Program data phase requested |
| xfer_done | input | 1 | Program data phase finished |
| stat_req | output | 1 | Status byte awaited |
| stat_valid | input | 1 | Status byte present |
| stat_byte | input | 8 | Status byte from the device |

## Verification
A wrong geometry selection or a wrong extra-cycle decision shows within the first few bus cycles of a request, as a missing, extra or shifted address byte. That is why each page geometry is exercised with an index whose bytes are all distinct. A sequencing fault after the address, such as a skipped data phase, a missing confirm command or a dropped status read, shows as the wrong trailing command, or as done arriving without stat_req or xfer_req ever rising. A faulty range comparison shows at once, because done fires the cycle after acceptance with no bus traffic, so the cases on both sides of each limit are checked.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int BLK_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [23:0]      req_index,
  input  logic             cfg_large,
  input  logic             cfg_blk128,
  input  logic             cfg_extra,
  input  logic [BLK_W-1:0] cfg_blocks,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             bad_idx,
  output logic             cyc_valid,
  input  logic             cyc_ready,
  output logic             cyc_is_addr,
  output logic [7:0]       cyc_byte,
  input  logic             nand_rdy,
  output logic             xfer_req,
  input  logic             xfer_done,
  output logic             stat_req,
  input  logic             stat_valid,
  input  logic [7:0]       stat_byte
);
  localparam int IDX_W = 24;
  localparam int LIM_W = BLK_W + 7;
  localparam int LST_N = 8;

  localparam logic [2:0] OP_RST = 3'd0, OP_RID = 3'd1, OP_RD = 3'd2,
                         OP_PRG = 3'd3, OP_ERS = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT0, S_EMIT, S_XFER, S_TAIL, S_WAIT1, S_STCMD, S_STRD, S_DONE
  } state_t;

  state_t           state;
  logic [2:0]       op_q;
  logic [IDX_W-1:0] idx_q;
  logic             large_q, extra_q, pass_q, bad_q;
  logic [2:0]       sh_q, step;

  logic [2:0]       sh_in;
  logic [LIM_W-1:0] page_lim;
  logic             is_page_op, bad_in;

  assign sh_in      = !cfg_large ? 3'd5 : (cfg_blk128 ? 3'd7 : 3'd6);
  assign page_lim   = LIM_W'(cfg_blocks) << sh_in;
  assign is_page_op = (req_op == OP_RD) || (req_op == OP_PRG);
  assign bad_in     = (req_op > OP_ERS) ||
                      (is_page_op && (LIM_W'(req_index) >= page_lim)) ||
                      ((req_op == OP_ERS) && (LIM_W'(req_index) >= LIM_W'(cfg_blocks)));

  logic [8:0]       lst [LST_N];
  logic [3:0]       n_lst;
  logic [IDX_W-1:0] row;

  assign row = (op_q == OP_ERS) ? (idx_q << sh_q) : idx_q;

  always_comb begin
    for (int k = 0; k < LST_N; k++) lst[k] = 9'h000;
    n_lst = 4'd0;
    case (op_q)
      OP_RST: begin
        lst[0] = {1'b0, 8'hFF}; n_lst = 4'd1;
      end
      OP_RID: begin
        lst[0] = {1'b0, 8'h90}; lst[1] = {1'b1, 8'h00}; n_lst = 4'd2;
      end
      OP_RD, OP_PRG: begin
        lst[0] = {1'b0, (op_q == OP_RD) ? 8'h00 : 8'h80};
        lst[1] = {1'b1, 8'h00};
        n_lst  = 4'd2;
        if (large_q) begin
          lst[n_lst[2:0]] = {1'b1, 8'h00}; n_lst = n_lst + 4'd1;
        end
        lst[n_lst[2:0]] = {1'b1, row[7:0]};  n_lst = n_lst + 4'd1;
        lst[n_lst[2:0]] = {1'b1, row[15:8]}; n_lst = n_lst + 4'd1;
        if (extra_q) begin
          lst[n_lst[2:0]] = {1'b1, row[23:16]}; n_lst = n_lst + 4'd1;
        end
        if (large_q && op_q == OP_RD) begin
          lst[n_lst[2:0]] = {1'b0, 8'h30}; n_lst = n_lst + 4'd1;
        end
      end
      OP_ERS: begin
        lst[0] = {1'b0, 8'h60};
        lst[1] = {1'b1, row[7:0]};
        lst[2] = {1'b1, row[15:8]};
        n_lst  = 4'd3;
        if (extra_q) begin
          lst[3] = {1'b1, row[23:16]}; n_lst = 4'd4;
        end
        lst[n_lst[2:0]] = {1'b0, 8'hD0}; n_lst = n_lst + 4'd1;
      end
      default: n_lst = 4'd0;
    endcase
  end

  logic last_item;
  assign last_item = ({1'b0, step} == (n_lst - 4'd1));

  assign busy        = (state != S_IDLE);
  assign done        = (state == S_DONE);
  assign pass        = pass_q;
  assign bad_idx     = bad_q;
  assign cyc_valid   = (state == S_EMIT) || (state == S_TAIL) || (state == S_STCMD);
  assign cyc_is_addr = (state == S_EMIT) && lst[step][8];
  assign cyc_byte    = (state == S_EMIT) ? lst[step][7:0] :
                       (state == S_TAIL) ? 8'h10 : 8'h70;
  assign xfer_req    = (state == S_XFER);
  assign stat_req    = (state == S_STRD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_RST;
      idx_q   <= '0;
      large_q <= 1'b0;
      extra_q <= 1'b0;
      sh_q    <= 3'd5;
      step    <= 3'd0;
      pass_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_q    <= req_op;
          idx_q   <= req_index;
          large_q <= cfg_large;
          extra_q <= cfg_extra;
          sh_q    <= sh_in;
          step    <= 3'd0;
          pass_q  <= 1'b0;
          bad_q   <= bad_in;
          if (bad_in)                state <= S_DONE;
          else if (req_op == OP_RST) state <= S_EMIT;
          else                       state <= S_WAIT0;
        end
        S_WAIT0: if (nand_rdy) state <= S_EMIT;
        S_EMIT: if (cyc_ready) begin
          if (last_item) begin
            case (op_q)
              OP_RST: begin pass_q <= 1'b1; state <= S_DONE; end
              OP_PRG: state <= S_XFER;
              default: state <= S_WAIT1;
            endcase
          end else begin
            step <= step + 3'd1;
          end
        end
        S_XFER: if (xfer_done) state <= S_TAIL;
        S_TAIL: if (cyc_ready) state <= S_WAIT1;
        S_WAIT1: if (nand_rdy) begin
          if (op_q == OP_PRG || op_q == OP_ERS) state <= S_STCMD;
          else begin pass_q <= 1'b1; state <= S_DONE; end
        end
        S_STCMD: if (cyc_ready) state <= S_STRD;
        S_STRD: if (stat_valid) begin
          pass_q <= ((stat_byte & 8'h41) == 8'h40);
          state  <= S_DONE;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       pass,
  input logic       bad_idx,
  input logic       cyc_valid,
  input logic       cyc_ready,
  input logic       cyc_is_addr,
  input logic [7:0] cyc_byte,
  input logic       xfer_req,
  input logic       stat_req
);
  AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !cyc_ready |=> cyc_valid && $stable(cyc_byte) && $stable(cyc_is_addr)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !done && !cyc_valid && !xfer_req && !stat_req); // R2
  AST_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    done && bad_idx |-> !pass && !$past(cyc_valid)); // R11
  AST_XFER_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !cyc_valid && !stat_req); // R7
  AST_STAT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_req |-> !cyc_valid && !done); // R10
endmodule

bind nand_seq nand_seq_chk u_chk (.*);

// File: tb/nand_seq_tb.sv
`timescale 1ns/1ps
module nand_seq_tb;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0;
  logic [2:0]  req_op = 0;
  logic [23:0] req_index = 0;
  logic        cfg_large = 0, cfg_blk128 = 0, cfg_extra = 0;
  logic [16:0] cfg_blocks = 17'd1024;
  logic        busy, done, pass, bad_idx, cyc_valid, cyc_is_addr, xfer_req, stat_req;
  logic [7:0]  cyc_byte;
  logic        cyc_ready = 1, nand_rdy = 1, xfer_done = 0, stat_valid = 0;
  logic [7:0]  stat_byte = 8'h40;
  logic        bp = 0;

  nand_seq u_dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [8:0] cap[$];
  logic [8:0] exp[$];
  bit got_done, got_pass, got_bad;

  always @(negedge clk) begin
    cyc_ready  = bp ? ~cyc_ready : 1'b1;
    xfer_done  = xfer_req && !xfer_done;
    stat_valid = stat_req && !stat_valid;
  end

  always @(negedge clk) begin
    #1;
    if (cyc_valid && cyc_ready) cap.push_back({cyc_is_addr, cyc_byte});
    if (done) begin got_done = 1; got_pass = pass; got_bad = bad_idx; end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic pc(int b); exp.push_back({1'b0, 8'(b)}); endtask
  task automatic pa(int b); exp.push_back({1'b1, 8'(b)}); endtask

  task automatic page_addr(int idx);
    pa(0);
    if (cfg_large) pa(0);
    pa(idx & 8'hFF); pa((idx >> 8) & 8'hFF);
    if (cfg_extra) pa((idx >> 16) & 8'hFF);
  endtask

  task automatic chk_seq(string req);
    int bad = -1;
    if (cap.size() != exp.size()) bad = 999;
    else foreach (cap[i]) if (cap[i] !== exp[i] && bad < 0) bad = i;
    if (bad == 999) chk(0, {req, " length"}, cap.size(), exp.size());
    else if (bad >= 0) chk(0, {req, " cycle"}, cap[bad], exp[bad]);
    else chk(1, req, 0, 0);
  endtask

  task automatic issue(int op, int idx);
    cap.delete(); got_done = 0;
    @(negedge clk); req_op = 3'(op); req_index = 24'(idx); req_valid = 1;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!got_done && n < 400) begin @(negedge clk); n++; end
    #2;
    if (!got_done) chk(0, {req, " no done"}, 0, 1);
  endtask

  task automatic run(int op, int idx, string req, bit exp_pass, bit exp_bad);
    issue(op, idx);
    wait_done(req);
    chk_seq(req);
    chk(got_pass == exp_pass && got_bad == exp_bad, {req, " result"},
        {got_pass, got_bad}, {exp_pass, exp_bad});
  endtask

  task automatic t_reset_state;
    chk(!busy && !done && !cyc_valid && !xfer_req && !stat_req, "R1 in reset",
        {busy, done, cyc_valid, xfer_req, stat_req}, 0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    chk(!busy && !done && !cyc_valid && !xfer_req && !stat_req, "R1 after reset",
        {busy, done, cyc_valid, xfer_req, stat_req}, 0);
  endtask

  task automatic t_reset_op;
    exp.delete(); pc(8'hFF);
    nand_rdy = 0;
    run(0, 0, "R4 reset op", 1, 0);
    nand_rdy = 1;
  endtask

  task automatic t_read_id_bp;
    bp = 1;
    exp.delete(); pc(8'h90); pa(8'h00);
    run(1, 0, "R5 R3 id read under backpressure", 1, 0);
    bp = 0;
  endtask

  task automatic t_reads;
    cfg_large = 0; cfg_extra = 1; cfg_blocks = 17'd4096;
    exp.delete(); pc(8'h00); page_addr(24'h01A2B3);
    run(2, 24'h01A2B3, "R6 small read extra", 1, 0);
    cfg_large = 1; cfg_blk128 = 0; cfg_extra = 0; cfg_blocks = 17'd1024;
    exp.delete(); pc(8'h00); page_addr(24'h00BEEF); pc(8'h30);
    run(2, 24'h00BEEF, "R6 large read", 1, 0);
  endtask

  task automatic t_programs;
    cfg_large = 1; cfg_blk128 = 1; cfg_extra = 1; cfg_blocks = 17'd1024;
    stat_byte = 8'h40;
    exp.delete(); pc(8'h80); page_addr(24'h012345); pc(8'h10); pc(8'h70);
    run(3, 24'h012345, "R7 R10 program pass", 1, 0);
    cfg_large = 0; cfg_extra = 0; stat_byte = 8'h41;
    exp.delete(); pc(8'h80); page_addr(24'h000321); pc(8'h10); pc(8'h70);
    run(3, 24'h000321, "R7 R10 program error bit", 0, 0);
  endtask

  task automatic t_erases;
    cfg_large = 0; cfg_extra = 1; cfg_blocks = 17'd1024; stat_byte = 8'h00;
    exp.delete(); pc(8'h60); pa(8'h60); pa(8'h55); pa(8'h00); pc(8'hD0); pc(8'h70);
    run(4, 24'h0002AB, "R8 R9 R10 erase small not-ready status", 0, 0);
    cfg_large = 1; cfg_blk128 = 1; cfg_extra = 0; stat_byte = 8'h40;
    exp.delete(); pc(8'h60); pa(8'h80); pa(8'hAA); pc(8'hD0); pc(8'h70);
    run(4, 24'h000155, "R8 R9 erase large 128", 1, 0);
    cfg_blk128 = 0; cfg_extra = 1;
    exp.delete(); pc(8'h60); pa(8'hC0); pa(8'hFF); pa(8'h00); pc(8'hD0); pc(8'h70);
    run(4, 24'h0003FF, "R8 R9 R11 erase large 64 last block", 1, 0);
  endtask

  task automatic t_range;
    cfg_large = 0; cfg_extra = 0; cfg_blocks = 17'd1024;
    exp.delete();
    run(2, 32768, "R11 page index at limit", 0, 1);
    exp.delete(); pc(8'h00); page_addr(32767);
    run(2, 32767, "R11 page index below limit", 1, 0);
    exp.delete();
    run(4, 1024, "R11 erase block at limit", 0, 1);
    exp.delete();
    run(7, 0, "R11 unknown op", 0, 1);
  endtask

  task automatic t_ready_wait;
    cfg_large = 0; cfg_extra = 0; cfg_blocks = 17'd1024; stat_byte = 8'h40;
    nand_rdy = 0;
    issue(4, 3);
    repeat (6) @(negedge clk);
    req_op = 0; req_valid = 1;
    @(negedge clk); req_valid = 0;
    repeat (4) @(negedge clk);
    chk(cap.size() == 0 && busy, "R12 R2 hold while not ready", cap.size(), 0);
    nand_rdy = 1;
    wait_done("R12");
    exp.delete(); pc(8'h60); pa(8'h60); pa(8'h00); pc(8'hD0); pc(8'h70);
    chk_seq("R2 R12 erase only, busy request ignored");
    @(negedge clk);
    chk(!busy && !done, "R2 idle after done", {busy, done}, 0);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_reset_op();
    t_read_id_bp();
    t_reads();
    t_programs();
    t_erases();
    t_range();
    t_ready_wait();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule